// File: doc/BRIEF.md
# I2C SCL Rate Generator

This block times the serial clock of an I2C master from a fast source clock. A fixed pre-divider slows the source clock first. A sample counter then counts those divided ticks and emits one step tick each time it wraps. A step counter counts step ticks, and each time it wraps a half-period of SCL ends and the SCL phase flips. A half-period therefore lasts `PRE_DIV × S × T` source cycles, where S is the sample count and T is the step count. Both counts are programmed minus one.

Two timing words feed the block. The normal-speed word serves standard and fast modes, with step counts up to 64. The high-speed word has its own sample and step fields, with step counts up to 8. It is selected only when its two low bits hold the enable code. While it is selected, the normal-speed word is ignored. Software usually parks that word at 0x1303 for the master-code phase. The selected setting is captured only when a half-period ends, so a new value never cuts a level short. When the run enable is low, the counters are cleared and SCL rests high.

Top module: `scl_rate_gen`

## Requirements
- R1: While reset is asserted and after its release, `scl_phase` is 1 and `sample_stb` and `half_tick` are 0 until the run enable is raised.
- R2: While `run_en` is 0, all counters are cleared, `scl_phase` is 1 from the next cycle on, and neither strobe pulses.
- R3: With `run_en` high, every SCL high level and every low level lasts exactly `PRE_DIV × S × T` source-clock cycles, where S = sample field + 1 and T = step field + 1.
- R4: In normal-speed mode the sample field is `sf_timing[10:8]` (S from 1 to 8) and the step field is `sf_timing[5:0]` (T from 1 to 64). Both extremes are honoured.
- R5: `sample_stb` is a one-cycle pulse that repeats every `PRE_DIV × S` source cycles while running.
- R6: When `hs_timing[1:0]` equals 2'b11, high-speed mode is selected. In that mode the sample field is `hs_timing[14:12]` (S from 1 to 8) and the step field is `hs_timing[10:8]` (T from 1 to 8).
- R7: In high-speed mode the contents of `sf_timing` have no effect on timing. The typical parked value is 0x1303.
- R8: When `hs_timing[1:0]` is not 2'b11 (for example, `hs_timing` is 0), only `sf_timing` sets the timing.
- R9: The selected setting is captured only at the end of a half-period. The half-period in progress keeps its old length, and `scl_phase` changes only at such an end (or when `run_en` drops).
- R10: `half_tick` pulses for exactly one cycle per SCL flip. The pulse comes in the first cycle in which `scl_phase` shows its new level, and it always coincides with a `sample_stb` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| run_en | input | 1 | Run enable; low clears counters and holds SCL high |
| sf_timing | input | 16 | Normal-speed timing word: sample field [10:8], step field [5:0] |
| hs_timing | input | 16 | High-speed word: enable code [1:0]=2'b11, sample field [14:12], step field [10:8] |
| scl_phase | output | 1 | SCL level to drive: 1 high, 0 low |
| sample_stb | output | 1 | One-cycle strobe at each sample-counter wrap |
| half_tick | output | 1 | One-cycle strobe at each half-period end |

## Verification
All three outputs are registered, so each of them changes one cycle after the counter wrap that causes it. The bench samples on the falling edge, which means a flip of `scl_phase` and its `half_tick` fall in the same sample. The bench measures lengths as the number of falling edges between two flips, starting from a sample in which a flip has just been seen. This makes every measured length land exactly on `PRE_DIV × S × T`, independent of pipeline depth. The first, partial half-period after a start or a setting change is always discarded. The only exception is the deliberate check that the half-period in progress keeps its old length.

// File: rtl/scl_div_pkg.sv
package scl_div_pkg;
  localparam int SAMP_W      = 3;
  localparam int SF_STEP_W   = 6;
  localparam int HS_STEP_W   = 3;
  localparam int WORD_W      = 16;
  localparam int SF_SAMP_LSB = 8;
  localparam int SF_STEP_LSB = 0;
  localparam int HS_SAMP_LSB = 12;
  localparam int HS_STEP_LSB = 8;
  localparam logic [1:0] HS_EN_CODE = 2'b11;

  typedef struct packed {
    logic                 hs;
    logic [SAMP_W-1:0]    samp;
    logic [SF_STEP_W-1:0] step;
  } div_cfg_t;
endpackage

// File: rtl/scl_wrap_cnt.sv
module scl_wrap_cnt #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         adv,
  input  logic [W-1:0] lim,
  output logic         wrap
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  assign wrap = adv && (cnt_q == lim);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)       cnt_d = '0;
    else if (wrap) cnt_d = '0;
    else if (adv)  cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R4: the count never passes its limit, even when the limit is reloaded
  p_cnt_in_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= lim);
endmodule

// File: rtl/scl_cfg_sel.sv
module scl_cfg_sel
  import scl_div_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] sf_timing,
  input  logic [WORD_W-1:0] hs_timing,
  output div_cfg_t          act_cfg
);
  div_cfg_t dec_cfg;
  div_cfg_t act_q;
  div_cfg_t act_d;
  logic     unused_bits;

  assign unused_bits = ^{sf_timing[15:11], sf_timing[7:6],
                         hs_timing[15], hs_timing[11], hs_timing[7:2]};

  always_comb begin
    dec_cfg.hs = (hs_timing[1:0] == HS_EN_CODE);
    if (dec_cfg.hs) begin
      dec_cfg.samp = hs_timing[HS_SAMP_LSB +: SAMP_W];
      dec_cfg.step = {{(SF_STEP_W-HS_STEP_W){1'b0}},
                      hs_timing[HS_STEP_LSB +: HS_STEP_W]};
    end else begin
      dec_cfg.samp = sf_timing[SF_SAMP_LSB +: SAMP_W];
      dec_cfg.step = sf_timing[SF_STEP_LSB +: SF_STEP_W];
    end
  end

  always_comb begin
    act_d = act_q;
    if (load) act_d = dec_cfg;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= '0;
    else        act_q <= act_d;
  end

  assign act_cfg = act_q;

  // R9: the active setting only moves on a load cycle
  p_cfg_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(act_q));
  // R6: a high-speed setting never carries a step count above 8
  p_hs_step_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    act_q.hs |-> (act_q.step < 6'd8));
endmodule

// File: rtl/scl_rate_gen.sv
module scl_rate_gen
  import scl_div_pkg::*;
#(
  parameter int PRE_DIV = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        run_en,
  input  logic [15:0] sf_timing,
  input  logic [15:0] hs_timing,
  output logic        scl_phase,
  output logic        sample_stb,
  output logic        half_tick
);
  localparam int PRE_W = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
  localparam logic [PRE_W-1:0] PRE_LIM = PRE_W'(PRE_DIV - 1);

  div_cfg_t act_cfg;
  logic     pre_tick;
  logic     step_tick;
  logic     half_evt;
  logic     load;
  logic     scl_q, scl_d;
  logic     stb_q, stb_d;
  logic     half_q, half_d;

  assign load = !run_en || half_evt;

  scl_cfg_sel u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .sf_timing (sf_timing),
    .hs_timing (hs_timing),
    .act_cfg   (act_cfg)
  );

  scl_wrap_cnt #(.W(PRE_W)) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (!run_en),
    .adv   (run_en),
    .lim   (PRE_LIM),
    .wrap  (pre_tick)
  );

  scl_wrap_cnt #(.W(SAMP_W)) u_samp (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (!run_en),
    .adv   (pre_tick),
    .lim   (act_cfg.samp),
    .wrap  (step_tick)
  );

  scl_wrap_cnt #(.W(SF_STEP_W)) u_step (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (!run_en),
    .adv   (step_tick),
    .lim   (act_cfg.step),
    .wrap  (half_evt)
  );

  always_comb begin
    scl_d  = scl_q;
    if (!run_en)       scl_d = 1'b1;
    else if (half_evt) scl_d = ~scl_q;
    stb_d  = step_tick;
    half_d = half_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q  <= 1'b1;
      stb_q  <= 1'b0;
      half_q <= 1'b0;
    end else begin
      scl_q  <= scl_d;
      stb_q  <= stb_d;
      half_q <= half_d;
    end
  end

  assign scl_phase  = scl_q;
  assign sample_stb = stb_q;
  assign half_tick  = half_q;

  // R2: an idle block rests high with no strobes
  p_idle_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> (scl_phase && !sample_stb && !half_tick));
  // R10: every half-period end is also a sample wrap
  p_half_with_stb_r10: assert property (@(posedge clk) disable iff (!rst_n)
    half_tick |-> sample_stb);
  // R9: while running, SCL moves only at a half-period end
  p_scl_moves_on_half_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(run_en) && (scl_phase != $past(scl_phase))) |-> half_tick);
endmodule

// File: tb/scl_rate_gen_bench.sv
module scl_rate_gen_bench;
  localparam int PRE = 3;

  logic        clk;
  logic        rst_n;
  logic        run_en;
  logic [15:0] sf_timing;
  logic [15:0] hs_timing;
  logic        scl_phase;
  logic        sample_stb;
  logic        half_tick;

  int n_run  = 0;
  int n_fail = 0;
  int wd     = 0;

  scl_rate_gen #(.PRE_DIV(PRE)) u_scl_rate_gen (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_en     (run_en),
    .sf_timing  (sf_timing),
    .hs_timing  (hs_timing),
    .scl_phase  (scl_phase),
    .sample_stb (sample_stb),
    .half_tick  (half_tick)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk) begin
    wd <= wd + 1;
    if (wd == 150000) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: act=%0d exp<150000 cycles", wd);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] sf_word(input int s, input int t);
    return 16'(((s - 1) << 8) | (t - 1));
  endfunction

  function automatic logic [15:0] hs_word(input int s, input int t);
    return 16'(((s - 1) << 12) | ((t - 1) << 8) | 3);
  endfunction

  // count cycles from the current sample to the next SCL flip
  task automatic meas_half(output int n, output int hc);
    logic prev;
    prev = scl_phase;
    n = 0; hc = 0;
    do begin
      @(negedge clk); n++;
      if (half_tick) hc++;
    end while (scl_phase == prev && n < 5000);
  endtask

  task automatic meas_stb(output int n);
    int g;
    g = 0;
    while (!sample_stb && g < 5000) begin @(negedge clk); g++; end
    n = 0;
    do begin @(negedge clk); n++; end while (!sample_stb && n < 5000);
  endtask

  task automatic restart();
    @(negedge clk); run_en = 1'b0;
    repeat (3) @(negedge clk);
    run_en = 1'b1;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; run_en = 1'b0; sf_timing = '0; hs_timing = '0;
    repeat (3) @(negedge clk);
    chk("R1 scl in reset", int'(scl_phase), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 scl after reset", int'(scl_phase), 1);
    chk("R1 strobes after reset", int'(sample_stb) + int'(half_tick), 0);
  endtask

  task automatic t_idle();
    int act;
    int n, hc;
    sf_timing = sf_word(1, 1);
    act = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      act += int'(sample_stb) + int'(half_tick) + int'(!scl_phase);
    end
    chk("R2 idle activity", act, 0);
    run_en = 1'b1;
    meas_half(n, hc);
    meas_half(n, hc);
    if (scl_phase) meas_half(n, hc);
    run_en = 1'b0;
    @(negedge clk);
    chk("R2 scl high after stop", int'(scl_phase), 1);
    act = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      act += int'(sample_stb) + int'(half_tick);
    end
    chk("R2 no strobes after stop", act, 0);
  endtask

  task automatic t_sf(input string req, input int s, input int t);
    int n, hc;
    sf_timing = sf_word(s, t); hs_timing = '0;
    restart();
    meas_half(n, hc);
    meas_half(n, hc);
    chk({req, " half A"}, n, PRE * s * t);
    chk("R10 one half_tick per flip", hc, 1);
    meas_half(n, hc);
    chk({req, " half B"}, n, PRE * s * t);
  endtask

  task automatic t_stb(input int s, input int t);
    int n;
    sf_timing = sf_word(s, t); hs_timing = '0;
    restart();
    meas_stb(n);
    meas_stb(n);
    chk("R5 sample_stb spacing", n, PRE * s);
  endtask

  task automatic t_hs(input int s, input int t);
    int n, hc;
    sf_timing = 16'h1303; hs_timing = hs_word(s, t);
    restart();
    meas_half(n, hc);
    meas_half(n, hc);
    chk("R6 high-speed half", n, PRE * s * t);
    sf_timing = sf_word(8, 64);
    meas_half(n, hc);
    meas_half(n, hc);
    chk("R7 sf ignored in hs", n, PRE * s * t);
  endtask

  task automatic t_hs_off();
    int n, hc;
    sf_timing = sf_word(3, 5); hs_timing = hs_word(2, 2);
    restart();
    meas_half(n, hc);
    meas_half(n, hc);
    hs_timing = 16'h0000;
    meas_half(n, hc);
    meas_half(n, hc);
    chk("R8 hs cleared uses sf", n, PRE * 3 * 5);
    hs_timing = 16'h7702;
    meas_half(n, hc);
    meas_half(n, hc);
    chk("R8 no enable code uses sf", n, PRE * 3 * 5);
  endtask

  task automatic t_midchange();
    int n, hc;
    sf_timing = sf_word(4, 6); hs_timing = '0;
    restart();
    meas_half(n, hc);
    meas_half(n, hc);
    repeat (5) @(negedge clk);
    sf_timing = sf_word(2, 3);
    meas_half(n, hc);
    chk("R9 current half keeps old", n + 5, PRE * 4 * 6);
    meas_half(n, hc);
    chk("R9 next half uses new", n, PRE * 2 * 3);
  endtask

  initial begin
    t_reset();
    t_idle();
    t_sf("R3", 2, 3);
    t_sf("R4 max", 8, 64);
    t_sf("R4 min", 1, 1);
    t_sf("R4 mixed", 5, 17);
    t_stb(3, 4);
    t_stb(1, 9);
    t_hs(2, 5);
    t_hs(8, 8);
    t_hs_off();
    t_midchange();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule